// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits between a group of 16 requesting lanes and a scratchpad divided into 16 banks of 32-bit words. A request vector carries, for each lane, an active flag and a word address. The low address bits pick the bank and the remaining bits pick the row inside that bank, so consecutive words fall into consecutive banks. The block spreads the vector's reads over as few cycles as it can. In each cycle every bank receives at most one row. All lanes that ask for the same word are answered together from that one bank read.

A bank returns data one cycle after it is enabled. When every active lane has its word, the block raises a one-cycle completion pulse. In that same cycle it presents the per-lane results and the number of issue cycles it spent. That number is the largest count of distinct words requested from any single bank. Conflicts are counted only inside one vector. A new vector is taken only while the block is idle, which is from the completion pulse onwards.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A word address A is sent to bank (A mod 16) as row (A div 16), meaning address bits [3:0] select the bank and bits [9:4] form the row.
- R2: When every active lane targets a different bank, the vector uses exactly one issue cycle.
- R3: When all active lanes request the same word, the vector uses exactly one issue cycle and every lane receives that word.
- R4: `cycles_used` equals the maximum number of distinct words requested from any one bank: stride 2 gives 2, stride 8 gives 8, and stride 16 gives 16.
- R5: In each issue cycle a bank is enabled at most once. Each distinct word is read exactly once. Inside a bank, pending words are served in the order of the lowest-numbered lane that requests them. No bank is enabled while the block is idle.
- R6: In the completion cycle, each active lane's slot in `rsp_data` holds the word stored at its address. Each inactive lane's slot holds zero.
- R7: `done` is a one-cycle pulse, raised N+1 clock edges after the accepting edge, where N is `cycles_used`. A vector with no active lanes completes with `cycles_used` = 0.
- R8: `req_ready` is low from the accepting edge until the completion pulse. While it is low, `req_valid`, `lane_act` and `lane_addr` have no effect on the vector in progress.
- R9: After reset, `req_ready` = 1, `done` = 0, `bank_en` = 0, `cycles_used` = 0 and `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request vector is presented |
| req_ready | output | 1 | Block is idle and will take a vector |
| lane_act | input | 16 | Active flag per lane |
| lane_addr | input | 160 | Word address per lane, 10 bits each, lane 0 in the low bits |
| bank_en | output | 16 | Read enable per bank |
| bank_row | output | 96 | Row per bank, 6 bits each |
| bank_rdata | input | 512 | Read data per bank, 32 bits each, valid one cycle after enable |
| rsp_data | output | 512 | Result word per lane, 32 bits each |
| done | output | 1 | One-cycle completion pulse |
| cycles_used | output | 5 | Issue cycles spent on the last vector |

## Verification
The checker watches four rules on every cycle:
- `done` lasts exactly one cycle and coincides with the idle state.
- An accepted vector drops `req_ready` on the next cycle.
- `req_ready` only rises together with `done`.
- No bank is enabled while the block is idle, and the reported cycle count never exceeds the lane count.

Other behaviour can only be shown through the bench's scenarios, which compare against counts and orderings computed separately. These are the exact cycle count for each conflict pattern, the row presented to each bank in each issue cycle, the lowest-lane service order, broadcast delivery, the returned data, and the immunity to inputs that change while busy.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
    localparam int DEF_LANES  = 16;
    localparam int DEF_BANKS  = 16;
    localparam int DEF_ADDR_W = 10;
    localparam int DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } bcs_state_e;

    // width able to hold the value n
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/bcs_bank_pick.sv
`timescale 1ns/1ps
// Per-bank selector: finds the lowest pending lane aimed at this bank,
// takes its word, and releases every pending lane asking for that word.
module bcs_bank_pick #(
    parameter int LANES    = 16,
    parameter int NBANK    = 16,
    parameter int ADDR_W   = 10,
    parameter int BANK_IDX = 0,
    localparam int BANK_W  = $clog2(NBANK),
    localparam int ROW_W   = ADDR_W - BANK_W
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    output logic                    en,
    output logic [ROW_W-1:0]        row,
    output logic [LANES-1:0]        grant
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_IDX);

    logic [ADDR_W-1:0] la [LANES];
    logic [ADDR_W-1:0] sel;
    logic              found;

    for (genvar l = 0; l < LANES; l++) begin : g_unpack
        assign la[l] = addr_flat[l*ADDR_W +: ADDR_W];
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pend[l] && (la[l][BANK_W-1:0] == MY_BANK)) begin
                found = 1'b1;
                sel   = la[l];
            end
        end
        for (int l = 0; l < LANES; l++) begin
            grant[l] = found && pend[l] && (la[l] == sel);
        end
        en  = found;
        row = sel[ADDR_W-1:BANK_W];
    end
endmodule

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accept, issue until nothing is pending, one drain cycle
// for the last read data, then pulse completion.
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int LANES = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LANES-1:0] lane_act,
    input  logic [LANES-1:0] grant_all,
    output logic             load,
    output logic             req_ready,
    output logic             issuing,
    output logic [LANES-1:0] pend_q,
    output logic [LANES-1:0] cap_q,
    output logic             done,
    output logic [CNT_W-1:0] cycles_used
);
    bcs_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LANES-1:0] left;

    assign req_ready = (state_q == ST_IDLE);
    assign issuing   = (state_q == ST_ISSUE);
    assign load      = req_ready && req_valid;
    assign left      = pend_q & ~grant_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_q      <= '0;
            cap_q       <= '0;
            cnt_q       <= '0;
            done        <= 1'b0;
            cycles_used <= '0;
        end else begin
            done  <= 1'b0;
            cap_q <= '0;
            case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        pend_q  <= lane_act;
                        cnt_q   <= '0;
                        state_q <= (lane_act == '0) ? ST_DRAIN : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    pend_q <= left;
                    cap_q  <= grant_all;
                    cnt_q  <= cnt_q + CNT_W'(1);
                    if (left == '0) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    done        <= 1'b1;
                    cycles_used <= cnt_q;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bcs_resp.sv
`timescale 1ns/1ps
// Per-lane result registers: each lane takes its bank's data in the
// cycle after its read was issued; cleared when a vector is accepted.
module bcs_resp #(
    parameter int LANES  = 16,
    parameter int NBANK  = 16,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [LANES-1:0]        cap,
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [NBANK*DATA_W-1:0] bank_rdata,
    output logic [LANES*DATA_W-1:0] rsp
);
    logic [BANK_W-1:0] bsel [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_bsel
        assign bsel[l] = addr_flat[l*ADDR_W +: BANK_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rsp <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (cap[l]) rsp[l*DATA_W +: DATA_W] <= bank_rdata[int'(bsel[l])*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/bank_conflict_serializer.sv
`timescale 1ns/1ps
module bank_conflict_serializer
    import bcs_pkg::*;
#(
    parameter int LANES  = DEF_LANES,
    parameter int NBANK  = DEF_BANKS,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROW_W  = ADDR_W - BANK_W,
    localparam int CNT_W  = count_width(LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        lane_act,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    output logic [NBANK-1:0]        bank_en,
    output logic [NBANK*ROW_W-1:0]  bank_row,
    input  logic [NBANK*DATA_W-1:0] bank_rdata,
    output logic [LANES*DATA_W-1:0] rsp_data,
    output logic                    done,
    output logic [CNT_W-1:0]        cycles_used
);
    logic                    load;
    logic                    issuing;
    logic [LANES-1:0]        pend_q;
    logic [LANES-1:0]        cap_q;
    logic [LANES-1:0]        grant_all;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [NBANK-1:0]        pick_en;
    logic [LANES-1:0]        grant_b [NBANK];

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= lane_addr;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bcs_bank_pick #(
            .LANES(LANES), .NBANK(NBANK), .ADDR_W(ADDR_W), .BANK_IDX(b)
        ) u_pick (
            .pend     (pend_q),
            .addr_flat(addr_q),
            .en       (pick_en[b]),
            .row      (bank_row[b*ROW_W +: ROW_W]),
            .grant    (grant_b[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < NBANK; b++) grant_all |= grant_b[b];
    end

    assign bank_en = pick_en & {NBANK{issuing}};

    bcs_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .lane_act   (lane_act),
        .grant_all  (grant_all & {LANES{issuing}}),
        .load       (load),
        .req_ready  (req_ready),
        .issuing    (issuing),
        .pend_q     (pend_q),
        .cap_q      (cap_q),
        .done       (done),
        .cycles_used(cycles_used)
    );

    bcs_resp #(
        .LANES(LANES), .NBANK(NBANK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .cap       (cap_q),
        .addr_flat (addr_q),
        .bank_rdata(bank_rdata),
        .rsp       (rsp_data)
    );
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker #(
    parameter int LANES = 16,
    parameter int NBANK = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [NBANK-1:0] bank_en,
    input logic             done,
    input logic [CNT_W-1:0] cycles_used
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> done);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_no_issue_idle_r5: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bank_en == '0));

    p_cycles_bound_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (cycles_used <= CNT_W'(LANES)));
endmodule

bind bank_conflict_serializer bcs_checker #(
    .LANES(LANES), .NBANK(NBANK), .CNT_W(CNT_W)
) u_bcs_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .bank_en    (bank_en),
    .done       (done),
    .cycles_used(cycles_used)
);

// File: tb/bank_conflict_serializer_test.sv
`timescale 1ns/1ps
module bank_conflict_serializer_test;
    localparam int L  = 16;
    localparam int NB = 16;
    localparam int AW = 10;
    localparam int DW = 32;
    localparam int RW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [L-1:0]   lane_act = '0;
    logic [L*AW-1:0] lane_addr = '0;
    logic [NB-1:0]  bank_en;
    logic [NB*RW-1:0] bank_row;
    logic [NB*DW-1:0] mem_q = '0;
    logic [L*DW-1:0] rsp_data;
    logic           done;
    logic [4:0]     cycles_used;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [L-1:0]  cur_act;
    logic [AW-1:0] cur_addr [L];
    int            nd [NB];
    logic [RW-1:0] erow [NB][L];
    int            exp_n;

    always #2.5 clk = ~clk;

    bank_conflict_serializer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .lane_act(lane_act), .lane_addr(lane_addr), .bank_en(bank_en),
        .bank_row(bank_row), .bank_rdata(mem_q), .rsp_data(rsp_data),
        .done(done), .cycles_used(cycles_used)
    );

    function automatic logic [31:0] word_at(input int b, input int r);
        return 32'hC35A0000 ^ (32'(b) << 24) ^ (32'(r) * 32'h9E3779B1);
    endfunction

    // bank storage model: data one cycle after enable
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (bank_en[b]) mem_q[b*DW +: DW] <= word_at(b, int'(bank_row[b*RW +: RW]));
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    // expected distinct words per bank, in lowest-lane order
    task automatic calc_expected();
        exp_n = 0;
        for (int b = 0; b < NB; b++) nd[b] = 0;
        for (int l = 0; l < L; l++) begin
            if (cur_act[l]) begin
                int b;
                bit dup;
                b = int'(cur_addr[l][3:0]);
                dup = 0;
                for (int k = 0; k < nd[b]; k++)
                    if (erow[b][k] == cur_addr[l][9:4]) dup = 1;
                if (!dup) begin
                    erow[b][nd[b]] = cur_addr[l][9:4];
                    nd[b]++;
                end
            end
        end
        for (int b = 0; b < NB; b++) if (nd[b] > exp_n) exp_n = nd[b];
    endtask

    task automatic run_vec(input bit noise, input string req);
        int s;
        int done_at;
        int bad_issue;
        int bad_data;
        logic [31:0] d_act, d_exp;
        calc_expected();
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        lane_act  = cur_act;
        for (int l = 0; l < L; l++) lane_addr[l*AW +: AW] = cur_addr[l];
        @(posedge clk);
        #1;
        if (noise) begin
            lane_act = ~cur_act;
            for (int l = 0; l < L; l++) lane_addr[l*AW +: AW] = AW'($urandom);
        end else begin
            req_valid = 1'b0;
        end
        s = 0; done_at = 0; bad_issue = 0;
        while (done_at == 0 && s < 60) begin
            @(negedge clk);
            s++;
            for (int b = 0; b < NB; b++) begin
                bit exp_en;
                exp_en = (s <= nd[b]);
                if (bank_en[b] !== exp_en) bad_issue++;
                else if (exp_en && bank_row[b*RW +: RW] !== erow[b][s-1]) bad_issue++;
            end
            if (done) done_at = s;
        end
        req_valid = 1'b0;
        lane_act  = '0;
        chk(done_at == exp_n + 2, "R7", "done latency", done_at, exp_n + 2);
        chk(cycles_used == 5'(exp_n), req, "cycles_used", 32'(cycles_used), exp_n);
        chk(bad_issue == 0, "R1 R5", "bank issue mismatches", bad_issue, 0);
        bad_data = 0; d_act = '0; d_exp = '0;
        for (int l = 0; l < L; l++) begin
            logic [31:0] e;
            e = cur_act[l] ? word_at(int'(cur_addr[l][3:0]), int'(cur_addr[l][9:4])) : 32'h0;
            if (rsp_data[l*DW +: DW] !== e) begin
                if (bad_data == 0) begin d_act = rsp_data[l*DW +: DW]; d_exp = e; end
                bad_data++;
            end
        end
        chk(bad_data == 0, "R6", "lane data", d_act, d_exp);
        if (noise) chk(bad_data == 0 && done_at == exp_n + 2, "R8", "busy inputs ignored", bad_data, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
        chk(done == 1'b0 && bank_en == '0, "R9", "done/bank_en after reset", {bank_en, 15'b0, done}, 0);
        chk(cycles_used == 0 && rsp_data == '0, "R9", "cycles/rsp after reset", cycles_used, 0);

        // R2: stride 1, every lane its own bank
        cur_act = '1;
        for (int l = 0; l < L; l++) cur_addr[l] = AW'(l + 32);
        run_vec(0, "R2");
        // R3: broadcast of one word
        for (int l = 0; l < L; l++) cur_addr[l] = 10'h2A7;
        run_vec(0, "R3");
        // R4: stride 2 -> 2 cycles
        for (int l = 0; l < L; l++) cur_addr[l] = AW'(2 * l);
        run_vec(0, "R4");
        // R4: stride 8 -> 8 cycles
        for (int l = 0; l < L; l++) cur_addr[l] = AW'(8 * l + 3);
        run_vec(0, "R4");
        // R4: stride 16 -> 16 cycles
        for (int l = 0; l < L; l++) cur_addr[l] = AW'(16 * l + 5);
        run_vec(0, "R4");
        // R7: empty vector
        cur_act = '0;
        run_vec(0, "R7");
        // R5: lowest-lane order with duplicates in one bank
        cur_act = 16'h001F;
        cur_addr[0] = 10'h050; cur_addr[1] = 10'h010; cur_addr[2] = 10'h050;
        cur_addr[3] = 10'h030; cur_addr[4] = 10'h010;
        for (int l = 5; l < L; l++) cur_addr[l] = 10'h3FF;
        run_vec(0, "R5");
        // R8: inputs toggled while busy
        cur_act = '1;
        for (int l = 0; l < L; l++) cur_addr[l] = AW'(8 * l);
        run_vec(1, "R8");
        // random mix
        for (int v = 0; v < 40; v++) begin
            cur_act = 16'($urandom);
            for (int l = 0; l < L; l++)
                cur_addr[l] = (v % 2 == 0) ? AW'($urandom % 48) : AW'($urandom);
            run_vec(0, "R4");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #750000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule